// File: doc/BRIEF.md
# Host-to-Card Address Window Translator

This block decides whether a host bus access falls inside one of a set of programmable address windows and, if it does, relocates the address into the card's address space. Seven windows are provided in two classes. Windows 0 and 1 serve I/O cycles and resolve single bytes. Windows 2 through 6 serve memory cycles and resolve 4 KB pages. Each window holds a lower bound, an upper bound, an additive offset and an enable bit.

Software programs every field through a narrow write port. At run time the host side presents an address, a cycle-type flag and a valid strobe. One clock later the block reports whether any window matched, which window won, and the translated card address. Bus timing on the card side and data movement are handled elsewhere.

Top module: `hc_window_xlate`

## Requirements
- R1: After reset every window is disabled with all fields zero, and the outputs rsp_hit, rsp_win and rsp_addr are all zero.
- R2: Windows 0 and 1 are I/O windows. Each compares the full host address at byte resolution, and it matches when start <= address <= end (both bounds inclusive).
- R3: Windows 2 to 6 are memory windows. Each compares only host address bits [AW-1:12] (the page number) against its page bounds, inclusive at both ends.
- R4: An I/O hit yields rsp_addr = (req_addr + offset) mod 2^CW.
- R5: A memory hit yields rsp_addr[CW-1:12] = (req_addr[AW-1:12] + page offset) mod 2^(CW-12), with rsp_addr[11:0] equal to req_addr[11:0].
- R6: An I/O cycle (req_is_io=1) is compared only against windows 0 and 1, and a memory cycle (req_is_io=0) only against windows 2 to 6.
- R7: When several windows of the active class match, the one with the lowest number wins. Its number is reported on rsp_win.
- R8: A window whose end is below its start never matches.
- R9: A window whose enable bit is 0 never matches.
- R10: The result appears in the cycle after a valid strobe. After a cycle without req_valid, and after any miss, rsp_hit, rsp_win and rsp_addr are all zero.
- R11: A write with cfg_we=1 updates window cfg_win. cfg_fld selects the field: 0 = start, 1 = end, 2 = offset, 3 = enable (taken from cfg_wdata[0]). I/O windows take start and end from cfg_wdata[AW-1:0] and the offset from cfg_wdata[CW-1:0]. Memory windows take start and end from cfg_wdata[AW-1:12] and the offset from cfg_wdata[CW-1:12]. A write with cfg_win = 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Field write strobe |
| cfg_win | input | 3 | Window number being written |
| cfg_fld | input | 2 | Field select: start, end, offset or enable |
| cfg_wdata | input | AW | Write data |
| req_valid | input | 1 | Host access strobe |
| req_is_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| req_addr | input | AW | Host address |
| rsp_hit | output | 1 | A window matched the previous access |
| rsp_win | output | 3 | Number of the winning window |
| rsp_addr | output | CW | Translated card address |

## Verification
A corrupted bound register shows up as a hit or miss flipping at exactly one address just outside, or just inside, the window edge. It appears on the very next response, so the bench sweeps every byte near the I/O edges and every page near the memory edges. A wrong offset or a wrong low-bit pass-through shows up as a bad rsp_addr on the first hit in that window. A broken priority chain shows up as the wrong rsp_win only in overlap regions, which the sweep covers deliberately. A class-mixing fault shows up as a hit on an access of the opposite cycle type.

// File: rtl/hcw_pkg.sv
package hcw_pkg;
  localparam int IO_WINS   = 2;
  localparam int MEM_WINS  = 5;
  localparam int NUM_WINS  = IO_WINS + MEM_WINS;
  localparam int PAGE_BITS = 12;

  typedef enum logic [1:0] {
    FLD_START  = 2'd0,
    FLD_END    = 2'd1,
    FLD_OFFSET = 2'd2,
    FLD_ENABLE = 2'd3
  } fld_e;

  // inclusive bound test on zero-extended keys
  function automatic logic key_inside(input logic [63:0] key,
                                      input logic [63:0] lo,
                                      input logic [63:0] hi);
    return (lo <= key) && (key <= hi);
  endfunction
endpackage

// File: rtl/hcw_window.sv
module hcw_window
  import hcw_pkg::*;
#(
  parameter int AW  = 32,
  parameter int CW  = 26,
  parameter int LSB = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [1:0]    cfg_fld,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          class_ok,
  input  logic [AW-1:0] req_addr,
  output logic          hit,
  output logic [CW-1:0] xaddr
);
  localparam int KW = AW - LSB;
  localparam int OW = CW - LSB;

  logic [KW-1:0] start_q, end_q;
  logic [OW-1:0] off_q;
  logic          en_q;
  logic [KW-1:0] key;
  logic [OW-1:0] key_t;
  logic [OW-1:0] moved;
  logic          range_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      end_q   <= '0;
      off_q   <= '0;
      en_q    <= 1'b0;
    end else if (cfg_we && cfg_sel) begin
      case (fld_e'(cfg_fld))
        FLD_START:  start_q <= cfg_wdata[AW-1:LSB];
        FLD_END:    end_q   <= cfg_wdata[AW-1:LSB];
        FLD_OFFSET: off_q   <= cfg_wdata[CW-1:LSB];
        default:    en_q    <= cfg_wdata[0];
      endcase
    end
  end

  assign key      = req_addr[AW-1:LSB];
  assign key_t    = OW'(key);
  assign moved    = key_t + off_q;
  assign range_ok = key_inside(64'(key), 64'(start_q), 64'(end_q));
  assign hit      = en_q && class_ok && range_ok;

  generate
    if (LSB > 0) begin : g_paged
      assign xaddr = {moved, req_addr[LSB-1:0]};
    end else begin : g_byte
      assign xaddr = moved;
    end
  endgenerate

  AST_ENABLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel && cfg_fld == 2'd3) |=> (en_q == $past(cfg_wdata[0]))); // R11
  AST_START_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel && cfg_fld == 2'd0) |=> (start_q == $past(cfg_wdata[AW-1:LSB]))); // R11
endmodule

// File: rtl/hcw_pick.sv
module hcw_pick #(
  parameter int N  = 7,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  hits,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  grant
);
  always_comb begin
    any   = 1'b0;
    idx   = '0;
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) begin
        any   = 1'b1;
        idx   = IW'(i);
        grant = N'(1) << i;
      end
    end
  end

  always_comb begin
    AST_ONE_GRANT: assert ($onehot0(grant)); // R7
    AST_GRANT_IN_HITS: assert ((grant & ~hits) == '0); // R7
  end
endmodule

// File: rtl/hc_window_xlate.sv
module hc_window_xlate
  import hcw_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 26,
  localparam int NW = NUM_WINS,
  localparam int IW = $clog2(NW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_win,
  input  logic [1:0]    cfg_fld,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          req_valid,
  input  logic          req_is_io,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_hit,
  output logic [2:0]    rsp_win,
  output logic [CW-1:0] rsp_addr
);
  logic [NW-1:0] win_hit;
  logic [CW-1:0] win_xaddr [NW];
  logic          pick_any;
  logic [IW-1:0] pick_idx;
  logic [NW-1:0] pick_grant;
  logic [CW-1:0] sel_addr;

  generate
    for (genvar w = 0; w < NW; w++) begin : g_win
      localparam bit IS_IO = (w < IO_WINS);
      hcw_window #(
        .AW (AW),
        .CW (CW),
        .LSB(IS_IO ? 0 : PAGE_BITS)
      ) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_win == 3'(w)),
        .cfg_fld  (cfg_fld),
        .cfg_wdata(cfg_wdata),
        .class_ok (IS_IO ? req_is_io : !req_is_io),
        .req_addr (req_addr),
        .hit      (win_hit[w]),
        .xaddr    (win_xaddr[w])
      );
    end
  endgenerate

  hcw_pick #(.N(NW)) u_pick (
    .hits (win_hit),
    .any  (pick_any),
    .idx  (pick_idx),
    .grant(pick_grant)
  );

  always_comb begin
    sel_addr = '0;
    for (int w = 0; w < NW; w++)
      if (pick_grant[w]) sel_addr = win_xaddr[w];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_hit  <= 1'b0;
      rsp_win  <= '0;
      rsp_addr <= '0;
    end else if (req_valid && pick_any) begin
      rsp_hit  <= 1'b1;
      rsp_win  <= 3'(pick_idx);
      rsp_addr <= sel_addr;
    end else begin
      rsp_hit  <= 1'b0;
      rsp_win  <= '0;
      rsp_addr <= '0;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_hit && rsp_addr == '0)); // R10
  AST_IO_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_is_io) |=> (!rsp_hit || rsp_win < 3'(IO_WINS))); // R6
  AST_MEM_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_is_io) |=> (!rsp_hit || rsp_win >= 3'(IO_WINS))); // R6
  AST_PAGE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_is_io) |=> (!rsp_hit || rsp_addr[11:0] == $past(req_addr[11:0]))); // R5
  AST_WIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (rsp_win < 3'(NW))); // R7
endmodule

// File: tb/hc_window_xlate_test.sv
module hc_window_xlate_test;
  localparam int AW = 32;
  localparam int CW = 26;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_win = '0;
  logic [1:0]    cfg_fld = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          req_valid = 1'b0;
  logic          req_is_io = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          rsp_hit;
  logic [2:0]    rsp_win;
  logic [CW-1:0] rsp_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench-side copy of programmed fields (keys: bytes for I/O, pages for memory)
  logic [31:0] m_start [7];
  logic [31:0] m_end   [7];
  logic [31:0] m_off   [7];
  bit          m_en    [7];

  always #10 clk = ~clk;

  hc_window_xlate #(.AW(AW), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_win(cfg_win),
    .cfg_fld(cfg_fld), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
    .req_is_io(req_is_io), .req_addr(req_addr), .rsp_hit(rsp_hit),
    .rsp_win(rsp_win), .rsp_addr(rsp_addr)
  );

  task automatic wr(input int w, input int f, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_win = 3'(w); cfg_fld = 2'(f); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (w < 7) begin
      case (f)
        0: m_start[w] = (w < 2) ? d : (d >> 12);
        1: m_end[w]   = (w < 2) ? d : (d >> 12);
        2: m_off[w]   = (w < 2) ? (d & 32'h03FF_FFFF) : ((d & 32'h03FF_FFFF) >> 12);
        default: m_en[w] = d[0];
      endcase
    end
  endtask

  task automatic expect_of(input logic [31:0] a, input bit io,
                           output bit eh, output int ew, output logic [31:0] ea);
    eh = 0; ew = 0; ea = 0;
    for (int w = 0; w < 7; w++) begin
      logic [31:0] k;
      if (eh) continue;
      if ((w < 2) != io) continue;
      k = (w < 2) ? a : (a >> 12);
      if (m_en[w] && m_start[w] <= k && k <= m_end[w]) begin
        eh = 1; ew = w;
        if (w < 2) ea = (a + m_off[w]) & 32'h03FF_FFFF;
        else       ea = (((k + m_off[w]) & 32'h3FFF) << 12) | (a & 32'hFFF);
      end
    end
  endtask

  task automatic compare(input string tag, input bit eh, input int ew, input logic [31:0] ea);
    checks++;
    if (rsp_hit !== eh || int'(rsp_win) != ew || 32'(rsp_addr) !== ea) begin
      errors++;
      $display("FAIL %s: got hit=%0d win=%0d addr=%h, expected hit=%0d win=%0d addr=%h",
               tag, rsp_hit, rsp_win, rsp_addr, eh, ew, ea);
    end
  endtask

  task automatic probe(input string tag, input logic [31:0] a, input bit io);
    bit eh; int ew; logic [31:0] ea; string t;
    expect_of(a, io, eh, ew, ea);
    @(negedge clk);
    req_valid = 1'b1; req_is_io = io; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    if (tag != "") t = tag;
    else if (!eh) t = "R6/R8 miss";
    else if (io && a >= 32'h180 && a <= 32'h1FF) t = "R7 overlap";
    else if (io) t = "R2/R4 io";
    else t = "R3/R5 mem";
    compare(t, eh, ew, ea);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < 7; w++) begin
      m_start[w] = 0; m_end[w] = 0; m_off[w] = 0; m_en[w] = 0;
    end
    repeat (3) @(negedge clk);
    // R1: outputs zero straight after reset
    compare("R1 reset outputs", 0, 0, 0);
    rst_n = 1'b1;
    // R1/R9: all windows disabled, zero bounds would otherwise cover address 0
    probe("R1 disabled after reset", 32'h0, 1'b1);
    probe("R1 disabled after reset", 32'h0, 1'b0);

    // I/O windows
    wr(0, 0, 32'h100); wr(0, 1, 32'h1FF); wr(0, 2, 32'h0000_1000); wr(0, 3, 1);
    wr(1, 0, 32'h180); wr(1, 1, 32'h2FF); wr(1, 2, 32'h03FF_FF00); wr(1, 3, 1);
    // memory windows
    wr(2, 0, 32'h0001_0000); wr(2, 1, 32'h0001_FFFF); wr(2, 2, 32'h0010_0000); wr(2, 3, 1);
    wr(3, 0, 32'h0001_8000); wr(3, 1, 32'h0003_0FFF); wr(3, 2, 32'h0020_0000); wr(3, 3, 1);
    wr(4, 0, 32'h0004_0000); wr(4, 1, 32'h0003_F000); wr(4, 3, 1);            // R8 inverted
    wr(5, 0, 32'h0005_0000); wr(5, 1, 32'h0006_0000); wr(5, 3, 0);            // R9 disabled
    wr(6, 0, 32'hFFFF_0000); wr(6, 1, 32'hFFFF_FFFF); wr(6, 2, 32'h03FF_F000); wr(6, 3, 1);

    // R2/R4/R6/R7: every byte 0..0x3FF as I/O and memory cycle
    for (int a = 0; a < 32'h400; a++) begin
      probe("", 32'(a), 1'b1);
      probe("", 32'(a), 1'b0);
    end
    // R3/R5/R6/R8/R9: pages 0..0x7F and the top 32 pages, both cycle types
    for (int p = 0; p < 32'h80; p++) begin
      logic [31:0] a;
      a = (32'(p) << 12) | ((32'(p) * 32'h1F3) & 32'hFFF);
      probe("", a, 1'b0);
      probe("", a, 1'b1);
    end
    for (int p = 32'hFFFE0; p <= 32'hFFFFF; p++) begin
      probe("", (32'(p) << 12) | 32'hABC, 1'b0);
    end
    // R3: bytes at the very edges of a page bound
    probe("R3 page edge low", 32'h0001_0000, 1'b0);
    probe("R3 page edge high", 32'h0001_FFFF, 1'b0);
    probe("R3 below page", 32'h0000_FFFF, 1'b0);

    // R9: disable window 0, overlap part falls to window 1, the rest misses
    wr(0, 3, 0);
    probe("R9 disabled io", 32'h150, 1'b1);
    probe("R9 fallthrough", 32'h1A0, 1'b1);
    wr(0, 3, 1);
    // R11: write to window number 7 changes nothing
    wr(7, 0, 32'h0);
    wr(7, 3, 32'h0);
    probe("R11 ignored slot", 32'h150, 1'b1);
    probe("R11 ignored slot", 32'h0001_0123, 1'b0);
    // R11: offset field picks up only wdata[CW-1:0]
    wr(0, 2, 32'hFC00_0010);
    probe("R11 offset width", 32'h100, 1'b1);

    // R10: idle cycle gives zeros after a hit
    probe("R10 hit before idle", 32'h100, 1'b1);
    @(negedge clk);
    compare("R10 idle zeros", 0, 0, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule